// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Occupancy Flags

This block is an 18-bit synchronous FIFO. Its depth is set by a parameter, and the write and read sides share one clock. A parameter fixes the read behaviour when the block is built.

In standard mode the reader asks for every word with an active-low read enable, including the first word written into an empty FIFO. In fall-through mode the oldest word is placed on the output register without a request. Read enable then only advances to the next word.

Two mode-dependent flags report space and data: a space flag and a data flag. Their polarities and reset values differ between the modes. Three active-low threshold flags report occupancy:

- half-full;
- almost-empty, against an empty offset taken from an input;
- almost-full, against a full offset taken from an input.

An active-low output enable lets data reach the output. When the enable is high the output is forced to zero.

All flags are registered. After a clock edge, each flag reflects the occupancy resulting from that edge. "Occupancy" means the words held in storage. In fall-through mode this excludes a word that has already been moved to the output register.

Top module: `sync_fifo_dm`

## Requirements
- R1: While `rst` is high at a rising edge, the following hold after that edge:
  - storage is emptied and `dout` is zero;
  - `half_n` and `afull_n` are 1, and `aempty_n` is 0;
  - in standard mode (`FALL_THROUGH`=0), `space_flag`=1 and `data_flag`=0;
  - in fall-through mode (`FALL_THROUGH`=1), `space_flag`=0 and `data_flag`=1.
- R2: A word on `din` is stored at a rising edge when `wr_en_n`=0 and occupancy is below `DEPTH`. While occupancy equals `DEPTH`, `wr_en_n`=0 stores nothing.
- R3: In standard mode, `space_flag` is 0 exactly when occupancy equals `DEPTH`. It returns to 1 on the edge of a read that frees space.
- R4: In standard mode, an edge with `rd_en_n`=0 and occupancy above zero loads the oldest word into the output register. `data_flag` is 0 exactly when occupancy is zero. An edge with `rd_en_n`=0 at zero occupancy changes nothing.
- R5: An edge with `rd_en_n`=1 leaves the output register unchanged. In fall-through mode this holds while a word is presented (`data_flag`=0).
- R6: In fall-through mode, a word written into an empty FIFO appears on `dout`, and `data_flag` falls to 0, after the third rising edge following the write edge. No read enable is needed.
- R7: In fall-through mode, an edge with `rd_en_n`=0 while a word is presented consumes that word and presents the next visible word.
  - If there is none, `data_flag` goes to 1 on that edge.
  - The output register then holds its last value.
- R8: In fall-through mode, `space_flag` is 1 exactly when occupancy equals `DEPTH`.
- R9: `half_n` is 0 exactly when occupancy exceeds `DEPTH`/2.
- R10: `aempty_n` is 0 exactly when occupancy is at or below the `ae_ofs` value sampled at the last edge.
- R11: `afull_n` is 0 exactly when occupancy is at or above `DEPTH` minus the `af_ofs` value sampled at the last edge.
- R12: While `out_en_n`=1, `dout` is zero, and the FIFO's contents and flags are not affected by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Active-low write request |
| din | input | WIDTH (18) | Write data |
| rd_en_n | input | 1 | Active-low read request |
| out_en_n | input | 1 | Active-low output enable; high forces `dout` to zero |
| ae_ofs | input | CW (9) | Empty offset for the almost-empty threshold |
| af_ofs | input | CW (9) | Full offset for the almost-full threshold |
| dout | output | WIDTH (18) | Output register contents, gated by `out_en_n` |
| space_flag | output | 1 | Standard: 0 when full. Fall-through: 1 when full |
| data_flag | output | 1 | Standard: 0 when empty. Fall-through: 1 when no word is presented |
| half_n | output | 1 | Low when occupancy exceeds half the depth |
| aempty_n | output | 1 | Low when occupancy is at or below the empty offset |
| afull_n | output | 1 | Low when occupancy is at or above depth minus the full offset |

## Verification
The bench targets these corner cases:

- **Writes into a full FIFO.** A design that accepted them would overwrite the oldest word, and a later word would come out in the wrong order.
- **Reads from an empty FIFO.** A design that honoured them would move stale data to the output or drive the occupancy negative.
- **Fall-through latency.** A design that presented the first word one edge early or late would show a `dout` and `data_flag` mismatch in the cycle around the third edge.
- **Consuming the last presented word.** A wrong design would leave `data_flag` low and repeat that word.
- **Threshold boundaries under changing offsets.** Exactly half, at the empty offset, and at depth minus the full offset catch off-by-one comparisons.
- **Output enable held high while the state moves.** A design that let the enable gate the state would lose or freeze words.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef struct packed {
    logic space;
    logic data;
    logic half_n;
    logic aempty_n;
    logic afull_n;
  } sfd_flags_t;

endpackage

// File: rtl/sfd_store.sv
module sfd_store #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // write port, no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // registered read port doubles as the output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/sfd_ctrl.sv
module sfd_ctrl #(
  parameter int DEPTH        = 256,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic          mem_re,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_nx,
  output logic          head_nx
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic          do_wr;
  logic          pop;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  assign do_wr  = !wr_en_n && (occ != FULL_C);
  assign mem_we = do_wr;
  assign waddr  = wptr;
  assign mem_re = pop;
  assign raddr  = rptr;
  assign occ_nx = occ + CW'(do_wr) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      occ <= occ_nx;
      if (do_wr) begin
        wptr <= (wptr == LAST_C) ? '0 : wptr + AW'(1);
      end
      if (pop) begin
        rptr <= (rptr == LAST_C) ? '0 : rptr + AW'(1);
      end
    end
  end

  generate
    if (FALL_THROUGH) begin : g_ft
      // a written word becomes visible to the reader two edges after the write
      // so that the automatic load lands on the third edge
      logic [CW-1:0] vis;
      logic          wq1;
      logic          wq2;
      logic          pres;
      logic          consume;

      assign consume = pres && !rd_en_n;
      assign pop     = (!pres || consume) && (vis != '0);
      assign head_nx = pop || (pres && !consume);

      always_ff @(posedge clk) begin
        if (rst) begin
          vis  <= '0;
          wq1  <= 1'b0;
          wq2  <= 1'b0;
          pres <= 1'b0;
        end else begin
          vis  <= vis + CW'(wq2) - CW'(pop);
          wq1  <= do_wr;
          wq2  <= wq1;
          pres <= head_nx;
        end
      end
    end else begin : g_std
      assign pop     = !rd_en_n && (occ != '0);
      assign head_nx = (occ_nx != '0);
    end
  endgenerate

endmodule

// File: rtl/sfd_flags.sv
module sfd_flags
  import sfd_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] occ_nx,
  input  logic          head_nx,
  input  logic [CW-1:0] ae_ofs,
  input  logic [CW-1:0] af_ofs,
  output sfd_flags_t    flags
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic full_nx;
  logic af_hit;

  assign full_nx = (occ_nx == FULL_C);
  assign af_hit  = ({1'b0, occ_nx} + {1'b0, af_ofs}) >= {1'b0, FULL_C};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.space    <= !FALL_THROUGH;
      flags.data     <= FALL_THROUGH;
      flags.half_n   <= 1'b1;
      flags.aempty_n <= 1'b0;
      flags.afull_n  <= 1'b1;
    end else begin
      flags.space    <= FALL_THROUGH ? full_nx : !full_nx;
      flags.data     <= FALL_THROUGH ? !head_nx : head_nx;
      flags.half_n   <= !(occ_nx > HALF_C);
      flags.aempty_n <= !(occ_nx <= ae_ofs);
      flags.afull_n  <= !af_hit;
    end
  end

endmodule

// File: rtl/sync_fifo_dm.sv
module sync_fifo_dm
  import sfd_pkg::*;
#(
  parameter int WIDTH        = 18,
  parameter int DEPTH        = 256,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en_n,
  input  logic             out_en_n,
  input  logic [CW-1:0]    ae_ofs,
  input  logic [CW-1:0]    af_ofs,
  output logic [WIDTH-1:0] dout,
  output logic             space_flag,
  output logic             data_flag,
  output logic             half_n,
  output logic             aempty_n,
  output logic             afull_n
);

  logic             mem_we;
  logic             mem_re;
  logic [AW-1:0]    waddr;
  logic [AW-1:0]    raddr;
  logic [CW-1:0]    occ;
  logic [CW-1:0]    occ_nx;
  logic             head_nx;
  logic [WIDTH-1:0] out_q;
  sfd_flags_t       flags;

  sfd_ctrl #(.DEPTH(DEPTH), .FALL_THROUGH(FALL_THROUGH)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .mem_we(mem_we), .waddr(waddr), .mem_re(mem_re), .raddr(raddr),
    .occ(occ), .occ_nx(occ_nx), .head_nx(head_nx)
  );

  sfd_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(waddr), .wdata(din),
    .re(mem_re), .raddr(raddr), .rdata(out_q)
  );

  sfd_flags #(.DEPTH(DEPTH), .FALL_THROUGH(FALL_THROUGH)) flags_i (
    .clk(clk), .rst(rst), .occ_nx(occ_nx), .head_nx(head_nx),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .flags(flags)
  );

  assign dout       = out_en_n ? '0 : out_q;
  assign space_flag = flags.space;
  assign data_flag  = flags.data;
  assign half_n     = flags.half_n;
  assign aempty_n   = flags.aempty_n;
  assign afull_n    = flags.afull_n;

endmodule

// File: rtl/sync_fifo_dm_chk.sv
module sync_fifo_dm_chk #(
  parameter int WIDTH        = 18,
  parameter int DEPTH        = 256,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en_n,
  input logic             out_en_n,
  input logic [CW-1:0]    ae_ofs,
  input logic [CW-1:0]    af_ofs,
  input logic [CW-1:0]    occ,
  input logic [WIDTH-1:0] dout,
  input logic             data_flag,
  input logic             half_n,
  input logic             aempty_n,
  input logic             afull_n
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_C);

  assert_half_R9: assert property (@(posedge clk) disable iff (rst)
    half_n == !(occ > HALF_C));

  assert_aempty_R10: assert property (@(posedge clk) disable iff (rst)
    aempty_n == !(occ <= $past(ae_ofs)));

  assert_afull_R11: assert property (@(posedge clk) disable iff (rst)
    afull_n == !(({1'b0, occ} + {1'b0, $past(af_ofs)}) >= {1'b0, FULL_C}));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en_n && !out_en_n && (!FALL_THROUGH || !data_flag))
      |=> ($stable(dout) || out_en_n));

  generate
    if (!FALL_THROUGH) begin : g_std
      assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_C && rd_en_n) |=> (occ == FULL_C));

      assert_empty_flag_R4: assert property (@(posedge clk) disable iff (rst)
        data_flag == (occ != '0));
    end
  endgenerate

endmodule

bind sync_fifo_dm sync_fifo_dm_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .FALL_THROUGH(FALL_THROUGH)
) chk_i (
  .clk(clk), .rst(rst), .rd_en_n(rd_en_n), .out_en_n(out_en_n),
  .ae_ofs(ae_ofs), .af_ofs(af_ofs), .occ(occ), .dout(dout),
  .data_flag(data_flag), .half_n(half_n), .aempty_n(aempty_n),
  .afull_n(afull_n)
);

// File: tb/sync_fifo_dm_tb_top.sv
`timescale 1ns/1ps
module sync_fifo_dm_tb_top;

  localparam int W  = 18;
  localparam int D  = 16;
  localparam int CW = $clog2(D) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          oe_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [CW-1:0] ae_ofs = CW'(3);
  logic [CW-1:0] af_ofs = CW'(4);

  logic [W-1:0] s_dout, f_dout;
  logic s_space, s_data, s_half, s_ae, s_af;
  logic f_space, f_data, f_half, f_ae, f_af;

  always #2.5 clk = ~clk;

  sync_fifo_dm #(.WIDTH(W), .DEPTH(D), .FALL_THROUGH(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wr_en_n(wr_n), .din(din), .rd_en_n(rd_n),
    .out_en_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(s_dout),
    .space_flag(s_space), .data_flag(s_data), .half_n(s_half),
    .aempty_n(s_ae), .afull_n(s_af)
  );

  sync_fifo_dm #(.WIDTH(W), .DEPTH(D), .FALL_THROUGH(1'b1)) dut_f (
    .clk(clk), .rst(rst), .wr_en_n(wr_n), .din(din), .rd_en_n(rd_n),
    .out_en_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(f_dout),
    .space_flag(f_space), .data_flag(f_data), .half_n(f_half),
    .aempty_n(f_ae), .afull_n(f_af)
  );

  // behavioural reference model
  logic [W-1:0] sq[$];
  logic [W-1:0] fq[$];
  logic [W-1:0] ms_dout, mf_dout;
  int  mf_vis;
  bit  mf_ov, mf_w1, mf_w2;
  bit  sw, sr, fw, fc, fl;
  int  m_ae, m_af;
  bit  started = 0;

  always @(posedge clk) begin
    started = 1;
    m_ae = int'(ae_ofs);
    m_af = int'(af_ofs);
    if (rst) begin
      sq.delete(); fq.delete();
      ms_dout = '0; mf_dout = '0;
      mf_vis = 0; mf_ov = 0; mf_w1 = 0; mf_w2 = 0;
    end else begin
      sw = !wr_n && (sq.size() < D);
      sr = !rd_n && (sq.size() > 0);
      if (sr) ms_dout = sq.pop_front();
      if (sw) sq.push_back(din);

      fw = !wr_n && (fq.size() < D);
      fc = mf_ov && !rd_n;
      fl = (!mf_ov || fc) && (mf_vis > 0);
      if (fl) begin
        mf_dout = fq.pop_front();
        mf_ov = 1;
      end else if (fc) begin
        mf_ov = 0;
      end
      mf_vis = mf_vis + int'(mf_w2) - int'(fl);
      mf_w2 = mf_w1;
      mf_w1 = fw;
      if (fw) fq.push_back(din);
    end
  end

  int total = 0;
  int bad = 0;
  string ph = "R1";
  bit done = 0;

  task automatic chk(string tag, string nm, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] %s act=%h exp=%h at %0t", tag, ph, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int ss, fs;
      ss = sq.size();
      fs = fq.size();
      chk(oe_n ? "R12" : "R4", "std dout", s_dout, oe_n ? '0 : ms_dout);
      chk("R3", "std space", W'(s_space), W'(ss != D));
      chk("R4", "std data", W'(s_data), W'(ss != 0));
      chk("R9", "std half", W'(s_half), W'(!(ss > D/2)));
      chk("R10", "std aempty", W'(s_ae), W'(!(ss <= m_ae)));
      chk("R11", "std afull", W'(s_af), W'(!(ss + m_af >= D)));
      chk(oe_n ? "R12" : "R6", "ft dout", f_dout, oe_n ? '0 : mf_dout);
      chk("R8", "ft space", W'(f_space), W'(fs == D));
      chk("R7", "ft data", W'(f_data), W'(!mf_ov));
      chk("R9", "ft half", W'(f_half), W'(!(fs > D/2)));
      chk("R10", "ft aempty", W'(f_ae), W'(!(fs <= m_ae)));
      chk("R11", "ft afull", W'(f_af), W'(!(fs + m_af >= D)));
    end
  end

  task automatic cyc(bit w, bit r, bit o, logic [W-1:0] d);
    @(posedge clk);
    #1;
    wr_n = w; rd_n = r; oe_n = o; din = d;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog [%s] act=running exp=finished", ph);
    finish_run();
  end

  initial begin
    ph = "R1 reset";
    repeat (3) cyc(1, 1, 0, '0);
    @(posedge clk); #1 rst = 0;

    ph = "R2 R3 R8 R9 R11 fill past full";
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, W'(18'h100 + i));

    ph = "R5 hold";
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, '0);

    ph = "R12 output disabled";
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, '0);

    ph = "R4 R7 R10 drain past empty";
    for (int i = 0; i < 22; i++) cyc(1, 0, 0, '0);

    ph = "R6 first word latency";
    cyc(0, 1, 0, W'(18'h2AB));
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, '0);
    cyc(1, 0, 0, '0);
    cyc(1, 0, 0, '0);

    ph = "R2 R4 R6 R7 random mix";
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        ae_ofs = CW'($urandom_range(0, D - 1));
        af_ofs = CW'($urandom_range(1, D - 1));
      end
      cyc(($urandom_range(0, 99) < ((i / 250) % 2 ? 70 : 35)) ? 1'b0 : 1'b1,
          ($urandom_range(0, 99) < ((i / 250) % 2 ? 35 : 70)) ? 1'b0 : 1'b1,
          ($urandom_range(0, 9) == 0) ? 1'b1 : 1'b0,
          W'($urandom));
    end

    ph = "R1 mid-run reset";
    @(posedge clk); #1 rst = 1;
    cyc(0, 0, 0, W'(18'h3FFFF));
    @(posedge clk); #1 rst = 0; wr_n = 1; rd_n = 1;
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, '0);

    @(negedge clk);
    #1;
    finish_run();
  end

endmodule